// File: doc/BRIEF.md
# Windowed LZ Match Selector

This block sits between the parallel string-match stage and the static entropy coder of a dictionary compressor. Each cycle it accepts one window of `VEC` byte positions. Each position arrives with its raw byte and a candidate `(length, distance)` pair. A distance of zero marks a literal position. The block turns these overlapping candidates into a stream of per-position tokens that do not overlap. Each token is a literal, the start of an accepted match, or a position already covered by an earlier match.

Selection runs in two phases. The first phase looks at the whole window at once. It ignores every position still covered by a match accepted in an earlier window, and among the rest it picks the candidate whose end lies farthest. The second phase walks the window one position at a time, with one pipeline stage per position. It settles the region before that best match: it accepts a candidate there, truncates it where it would run into the best match, or falls back to a literal. How far the accepted match reaches into the next window is held in a register. That coverage is applied to the next window that is presented. A new window can be accepted every cycle.

Top module: `lz_match_selector`

## Requirements
- R1: After reset, `out_valid` is low, and the first window presented carries no coverage from any earlier window.
- R2: A position whose distance is zero, or whose length is below `MIN_LEN`, and that is not covered is emitted as kind 0 (literal). Its output byte equals the byte lane, and its output length and distance are zero.
- R3: Among the match candidates at or beyond the carried coverage, the one whose start plus length is largest is emitted as kind 1 (match start). It keeps its full length and distance.
- R4: When two candidates reach equally far, the candidate that starts earlier is chosen.
- R5: Every position after a match start and inside that match is emitted as kind 2 (covered), with byte, length and distance zero.
- R6: A match that runs past the end of its window covers the leading positions of the next valid window, exactly as many as the overrun. Cycles with `in_valid` low neither consume nor change that coverage.
- R7: Candidates at positions inside the carried coverage are ignored, even when they would reach farther than any other candidate.
- R8: Positions before the best match are settled left to right. A candidate there that fits is accepted, and the positions it spans are covered.
- R9: A candidate before the best match that would run into it is shortened to end at the start of the best match. If that leaves fewer than `MIN_LEN` bytes, the position becomes a literal.
- R10: Each valid window appears on the outputs exactly `VEC+1` cycles after it was accepted. Windows leave in order, one per cycle at full rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A window is presented this cycle |
| in_byte | input | VEC*8 | Raw byte of each position, position 0 in the low lane |
| in_len | input | VEC*LEN_W | Candidate match length of each position (at most VEC) |
| in_dist | input | VEC*DIST_W | Candidate distance of each position; zero marks a literal |
| out_valid | output | 1 | A resolved window is on the outputs |
| out_kind | output | VEC*2 | Token kind per position: 0 literal, 1 match start, 2 covered |
| out_byte | output | VEC*8 | Byte of literal positions, zero otherwise |
| out_len | output | VEC*LEN_W | Accepted length at match starts, zero otherwise |
| out_dist | output | VEC*DIST_W | Distance at match starts, zero otherwise |

## Verification
The bench builds the block with `VEC=8`, `DIST_W=6` and `MIN_LEN=3`. With windows this narrow, random lengths from 0 to 8 often reach past the window edge. They also often produce equal-reach pairs and land candidates just in front of the best match. So carry-over, ties and truncation below the minimum all show up under random stimulus as well as in the directed windows. Random bubbles between windows exercise the rule that coverage survives idle cycles. A reset taken while coverage is pending shows that the coverage is dropped.

// File: rtl/msel_pkg.sv
package msel_pkg;

    // Token kind carried per window position; the encoding is visible at the ports.
    typedef enum logic [1:0] {
        TK_LIT   = 2'd0,
        TK_MATCH = 2'd1,
        TK_COVER = 2'd2
    } tok_kind_e;

    // Minimum match length accepted by the entropy coder downstream.
    localparam int MSEL_MIN_LEN_DEFAULT = 3;

endpackage

// File: rtl/msel_reach_pick.sv
// Phase one: parallel farthest-reach pick plus the window-crossing coverage register.
module msel_reach_pick
    import msel_pkg::*;
#(
    parameter int VEC     = 16,
    parameter int LEN_W   = 5,
    parameter int DIST_W  = 15,
    parameter int MIN_LEN = 3,
    parameter int END_W   = 6,
    parameter int CAR_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [VEC*8-1:0]        in_byte,
    input  logic [VEC*LEN_W-1:0]    in_len,
    input  logic [VEC*DIST_W-1:0]   in_dist,
    output logic                    pk_valid,
    output logic [VEC*8-1:0]        pk_byte,
    output logic [VEC*LEN_W-1:0]    pk_len,
    output logic [VEC*DIST_W-1:0]   pk_dist,
    output logic [END_W-1:0]        pk_ptr,
    output logic                    pk_has_best,
    output logic [CAR_W-1:0]        pk_best
);

    localparam logic [END_W-1:0] MIN_E = END_W'(MIN_LEN);
    localparam logic [END_W-1:0] VEC_E = END_W'(VEC);

    logic [CAR_W-1:0] carry_q;
    logic [CAR_W-1:0] carry_nx;
    logic [END_W-1:0] carry_e;
    logic             found;
    logic [CAR_W-1:0] best_pos;
    logic [END_W-1:0] best_end;

    assign carry_e = END_W'(carry_q);

    always_comb begin
        found    = 1'b0;
        best_pos = '0;
        best_end = '0;
        for (int p = 0; p < VEC; p++) begin
            logic [END_W-1:0] c_len;
            logic [END_W-1:0] c_end;
            c_len = END_W'(in_len[p*LEN_W +: LEN_W]);
            c_end = END_W'(p) + c_len;
            // strict compare keeps the earliest start on equal reach
            if ((in_dist[p*DIST_W +: DIST_W] != '0) && (c_len >= MIN_E) &&
                (END_W'(p) >= carry_e) && (!found || (c_end > best_end))) begin
                found    = 1'b1;
                best_pos = CAR_W'(p);
                best_end = c_end;
            end
        end
        carry_nx = (found && (best_end > VEC_E)) ? CAR_W'(best_end - VEC_E) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q     <= '0;
            pk_valid    <= 1'b0;
            pk_byte     <= '0;
            pk_len      <= '0;
            pk_dist     <= '0;
            pk_ptr      <= '0;
            pk_has_best <= 1'b0;
            pk_best     <= '0;
        end else begin
            pk_valid <= in_valid;
            if (in_valid) begin
                carry_q     <= carry_nx;
                pk_byte     <= in_byte;
                pk_len      <= in_len;
                pk_dist     <= in_dist;
                pk_ptr      <= carry_e;
                pk_has_best <= found;
                pk_best     <= best_pos;
            end
        end
    end

    // R7
    best_after_carry_chk: assert property (@(posedge clk) disable iff (rst)
        pk_valid && pk_has_best |-> (END_W'(pk_best) >= pk_ptr));

    // R3
    best_is_match_chk: assert property (@(posedge clk) disable iff (rst)
        pk_valid && pk_has_best |->
            (pk_dist[pk_best*DIST_W +: DIST_W] != '0) &&
            (END_W'(pk_len[pk_best*LEN_W +: LEN_W]) >= MIN_E));

endmodule

// File: rtl/msel_lazy_step.sv
// Phase two: one serial resolution step, settling window position STEP.
module msel_lazy_step
    import msel_pkg::*;
#(
    parameter int VEC     = 16,
    parameter int LEN_W   = 5,
    parameter int DIST_W  = 15,
    parameter int MIN_LEN = 3,
    parameter int END_W   = 6,
    parameter int CAR_W   = 4,
    parameter int STEP    = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    up_valid,
    input  logic [VEC*8-1:0]        up_byte,
    input  logic [VEC*LEN_W-1:0]    up_len,
    input  logic [VEC*DIST_W-1:0]   up_dist,
    input  logic [END_W-1:0]        up_ptr,
    input  logic                    up_has_best,
    input  logic [CAR_W-1:0]        up_best,
    input  logic [VEC*2-1:0]        up_kind,
    input  logic [VEC*8-1:0]        up_obyte,
    input  logic [VEC*LEN_W-1:0]    up_olen,
    input  logic [VEC*DIST_W-1:0]   up_odist,
    output logic                    dn_valid,
    output logic [VEC*8-1:0]        dn_byte,
    output logic [VEC*LEN_W-1:0]    dn_len,
    output logic [VEC*DIST_W-1:0]   dn_dist,
    output logic [END_W-1:0]        dn_ptr,
    output logic                    dn_has_best,
    output logic [CAR_W-1:0]        dn_best,
    output logic [VEC*2-1:0]        dn_kind,
    output logic [VEC*8-1:0]        dn_obyte,
    output logic [VEC*LEN_W-1:0]    dn_olen,
    output logic [VEC*DIST_W-1:0]   dn_odist
);

    localparam logic [END_W-1:0] POS   = END_W'(STEP);
    localparam logic [END_W-1:0] MIN_E = END_W'(MIN_LEN);
    localparam logic [END_W-1:0] ONE_E = END_W'(1);

    logic [LEN_W-1:0]  my_len;
    logic [DIST_W-1:0] my_dist;
    logic [7:0]        my_byte;
    logic [END_W-1:0]  my_len_e;
    logic [END_W-1:0]  best_e;
    logic [END_W-1:0]  room;
    logic [END_W-1:0]  eff;
    logic              is_match;

    tok_kind_e         nx_kind;
    logic [LEN_W-1:0]  nx_len;
    logic [DIST_W-1:0] nx_dist;
    logic [7:0]        nx_byte;
    logic [END_W-1:0]  nx_ptr;

    logic [VEC*2-1:0]      kind_nx;
    logic [VEC*8-1:0]      obyte_nx;
    logic [VEC*LEN_W-1:0]  olen_nx;
    logic [VEC*DIST_W-1:0] odist_nx;

    always_comb begin
        my_len   = up_len[STEP*LEN_W +: LEN_W];
        my_dist  = up_dist[STEP*DIST_W +: DIST_W];
        my_byte  = up_byte[STEP*8 +: 8];
        my_len_e = END_W'(my_len);
        best_e   = END_W'(up_best);
        is_match = (my_dist != '0) && (my_len_e >= MIN_E);
        room     = (up_has_best && (POS < best_e)) ? (best_e - POS) : my_len_e;
        eff      = (my_len_e < room) ? my_len_e : room;

        nx_kind = TK_LIT;
        nx_len  = '0;
        nx_dist = '0;
        nx_byte = my_byte;
        nx_ptr  = POS + ONE_E;
        if (POS < up_ptr) begin
            nx_kind = TK_COVER;
            nx_byte = '0;
            nx_ptr  = up_ptr;
        end else if (up_has_best && (POS == best_e)) begin
            nx_kind = TK_MATCH;
            nx_len  = my_len;
            nx_dist = my_dist;
            nx_byte = '0;
            nx_ptr  = POS + my_len_e;
        end else if (is_match && (eff >= MIN_E)) begin
            nx_kind = TK_MATCH;
            nx_len  = LEN_W'(eff);
            nx_dist = my_dist;
            nx_byte = '0;
            nx_ptr  = POS + eff;
        end

        kind_nx  = up_kind;
        obyte_nx = up_obyte;
        olen_nx  = up_olen;
        odist_nx = up_odist;
        kind_nx[STEP*2 +: 2]            = nx_kind;
        obyte_nx[STEP*8 +: 8]           = nx_byte;
        olen_nx[STEP*LEN_W +: LEN_W]    = nx_len;
        odist_nx[STEP*DIST_W +: DIST_W] = nx_dist;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dn_valid    <= 1'b0;
            dn_byte     <= '0;
            dn_len      <= '0;
            dn_dist     <= '0;
            dn_ptr      <= '0;
            dn_has_best <= 1'b0;
            dn_best     <= '0;
            dn_kind     <= '0;
            dn_obyte    <= '0;
            dn_olen     <= '0;
            dn_odist    <= '0;
        end else begin
            dn_valid    <= up_valid;
            dn_byte     <= up_byte;
            dn_len      <= up_len;
            dn_dist     <= up_dist;
            dn_ptr      <= nx_ptr;
            dn_has_best <= up_has_best;
            dn_best     <= up_best;
            dn_kind     <= kind_nx;
            dn_obyte    <= obyte_nx;
            dn_olen     <= olen_nx;
            dn_odist    <= odist_nx;
        end
    end

    logic [1:0]       chk_kind;
    logic [END_W-1:0] chk_len;
    assign chk_kind = dn_kind[STEP*2 +: 2];
    assign chk_len  = END_W'(dn_olen[STEP*LEN_W +: LEN_W]);

    // R9
    gap_trunc_chk: assert property (@(posedge clk) disable iff (rst)
        dn_valid && dn_has_best && (POS < END_W'(dn_best)) && (chk_kind == TK_MATCH)
        |-> (POS + chk_len <= END_W'(dn_best)));

    // R8
    ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> (dn_ptr > POS));

endmodule

// File: rtl/lz_match_selector.sv
module lz_match_selector
    import msel_pkg::*;
#(
    parameter int VEC     = 16,
    parameter int DIST_W  = 15,
    parameter int MIN_LEN = MSEL_MIN_LEN_DEFAULT,
    localparam int LEN_W  = $clog2(VEC + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [VEC*8-1:0]        in_byte,
    input  logic [VEC*LEN_W-1:0]    in_len,
    input  logic [VEC*DIST_W-1:0]   in_dist,
    output logic                    out_valid,
    output logic [VEC*2-1:0]        out_kind,
    output logic [VEC*8-1:0]        out_byte,
    output logic [VEC*LEN_W-1:0]    out_len,
    output logic [VEC*DIST_W-1:0]   out_dist
);

    localparam int END_W = $clog2(2 * VEC) + 1;
    localparam int CAR_W = (VEC > 1) ? $clog2(VEC) : 1;
    localparam logic [END_W-1:0] MIN_E = END_W'(MIN_LEN);
    localparam logic [END_W-1:0] VEC_E = END_W'(VEC);

    logic                  s_valid    [VEC+1];
    logic [VEC*8-1:0]      s_byte     [VEC+1];
    logic [VEC*LEN_W-1:0]  s_len      [VEC+1];
    logic [VEC*DIST_W-1:0] s_dist     [VEC+1];
    logic [END_W-1:0]      s_ptr      [VEC+1];
    logic                  s_has_best [VEC+1];
    logic [CAR_W-1:0]      s_best     [VEC+1];
    logic [VEC*2-1:0]      s_kind     [VEC+1];
    logic [VEC*8-1:0]      s_obyte    [VEC+1];
    logic [VEC*LEN_W-1:0]  s_olen     [VEC+1];
    logic [VEC*DIST_W-1:0] s_odist    [VEC+1];

    msel_reach_pick #(
        .VEC(VEC), .LEN_W(LEN_W), .DIST_W(DIST_W),
        .MIN_LEN(MIN_LEN), .END_W(END_W), .CAR_W(CAR_W)
    ) u_pick (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .in_len     (in_len),
        .in_dist    (in_dist),
        .pk_valid   (s_valid[0]),
        .pk_byte    (s_byte[0]),
        .pk_len     (s_len[0]),
        .pk_dist    (s_dist[0]),
        .pk_ptr     (s_ptr[0]),
        .pk_has_best(s_has_best[0]),
        .pk_best    (s_best[0])
    );

    assign s_kind[0]  = '0;
    assign s_obyte[0] = '0;
    assign s_olen[0]  = '0;
    assign s_odist[0] = '0;

    for (genvar g = 0; g < VEC; g++) begin : g_step
        msel_lazy_step #(
            .VEC(VEC), .LEN_W(LEN_W), .DIST_W(DIST_W), .MIN_LEN(MIN_LEN),
            .END_W(END_W), .CAR_W(CAR_W), .STEP(g)
        ) u_step (
            .clk        (clk),
            .rst        (rst),
            .up_valid   (s_valid[g]),
            .up_byte    (s_byte[g]),
            .up_len     (s_len[g]),
            .up_dist    (s_dist[g]),
            .up_ptr     (s_ptr[g]),
            .up_has_best(s_has_best[g]),
            .up_best    (s_best[g]),
            .up_kind    (s_kind[g]),
            .up_obyte   (s_obyte[g]),
            .up_olen    (s_olen[g]),
            .up_odist   (s_odist[g]),
            .dn_valid   (s_valid[g+1]),
            .dn_byte    (s_byte[g+1]),
            .dn_len     (s_len[g+1]),
            .dn_dist    (s_dist[g+1]),
            .dn_ptr     (s_ptr[g+1]),
            .dn_has_best(s_has_best[g+1]),
            .dn_best    (s_best[g+1]),
            .dn_kind    (s_kind[g+1]),
            .dn_obyte   (s_obyte[g+1]),
            .dn_olen    (s_olen[g+1]),
            .dn_odist   (s_odist[g+1])
        );
    end

    assign out_valid = s_valid[VEC];
    assign out_kind  = s_kind[VEC];
    assign out_byte  = s_obyte[VEC];
    assign out_len   = s_olen[VEC];
    assign out_dist  = s_odist[VEC];

    // Output-side consistency monitors
    logic             kinds_ok, min_ok, run_ok, lead_ok, lit_ok, best_ok;
    logic [END_W-1:0] tail_n, tail_q, tail_ptr;

    always_comb begin
        kinds_ok = 1'b1;
        min_ok   = 1'b1;
        run_ok   = 1'b1;
        lead_ok  = 1'b1;
        lit_ok   = 1'b1;
        tail_n   = '0;
        for (int k = 0; k < VEC; k++) begin
            logic [1:0]       kd;
            logic [END_W-1:0] ln;
            kd = out_kind[k*2 +: 2];
            ln = END_W'(out_len[k*LEN_W +: LEN_W]);
            if (kd == 2'd3) kinds_ok = 1'b0;
            if ((kd == TK_LIT) && (out_byte[k*8 +: 8] != s_byte[VEC][k*8 +: 8])) lit_ok = 1'b0;
            if (kd == TK_MATCH) begin
                if ((ln < MIN_E) || (out_dist[k*DIST_W +: DIST_W] == '0)) min_ok = 1'b0;
                if (END_W'(k) + ln > VEC_E) tail_n = END_W'(k) + ln - VEC_E;
                for (int j = k + 1; j < VEC; j++) begin
                    if ((END_W'(j) < END_W'(k) + ln) && (out_kind[j*2 +: 2] != TK_COVER)) run_ok = 1'b0;
                end
            end
            if ((END_W'(k) < tail_q) && (kd != TK_COVER)) lead_ok = 1'b0;
            if ((END_W'(k) == tail_q) && (kd == TK_COVER)) lead_ok = 1'b0;
        end
        tail_ptr = (s_ptr[VEC] > VEC_E) ? (s_ptr[VEC] - VEC_E) : '0;
        best_ok  = !s_has_best[VEC] ||
                   ((out_kind[s_best[VEC]*2 +: 2] == TK_MATCH) &&
                    (out_len[s_best[VEC]*LEN_W +: LEN_W] == s_len[VEC][s_best[VEC]*LEN_W +: LEN_W]) &&
                    (out_dist[s_best[VEC]*DIST_W +: DIST_W] == s_dist[VEC][s_best[VEC]*DIST_W +: DIST_W]));
    end

    always_ff @(posedge clk) begin
        if (rst) tail_q <= '0;
        else if (out_valid) tail_q <= tail_n;
    end

    // R2
    kind_legal_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> kinds_ok && lit_ok);

    // R3
    match_len_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> min_ok && best_ok);

    // R5
    run_cover_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> run_ok);

    // R6
    cross_window_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> lead_ok && (tail_ptr == tail_n));

endmodule

// File: tb/lz_match_selector_bench.sv
`timescale 1ns/1ps
module lz_match_selector_bench;

    localparam int V   = 8;
    localparam int DW  = 6;
    localparam int ML  = 3;
    localparam int LW  = $clog2(V + 1);
    localparam int LAT = V + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [V*8-1:0]  in_byte = '0;
    logic [V*LW-1:0] in_len  = '0;
    logic [V*DW-1:0] in_dist = '0;
    logic            out_valid;
    logic [V*2-1:0]  out_kind;
    logic [V*8-1:0]  out_byte;
    logic [V*LW-1:0] out_len;
    logic [V*DW-1:0] out_dist;

    always #2 clk = ~clk;

    lz_match_selector #(.VEC(V), .DIST_W(DW), .MIN_LEN(ML)) u_lz_match_selector (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_byte(in_byte), .in_len(in_len), .in_dist(in_dist),
        .out_valid(out_valid), .out_kind(out_kind), .out_byte(out_byte),
        .out_len(out_len), .out_dist(out_dist)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    int a_byte [V];
    int a_len  [V];
    int a_dist [V];
    int m_carry = 0;

    logic [V*2-1:0]  e_kind;
    logic [V*8-1:0]  e_byte;
    logic [V*LW-1:0] e_len;
    logic [V*DW-1:0] e_dist;

    logic [V*2-1:0]  q_kind [$];
    logic [V*8-1:0]  q_byte [$];
    logic [V*LW-1:0] q_len  [$];
    logic [V*DW-1:0] q_dist [$];
    string           q_tag  [$];
    int              q_stamp[$];

    // Reference model written from the requirements
    function automatic void compute_expect();
        int best = -1;
        int best_end = 0;
        int q;
        for (int p = 0; p < V; p++) begin
            if (a_dist[p] != 0 && a_len[p] >= ML && p >= m_carry && (best < 0 || p + a_len[p] > best_end)) begin
                best = p;
                best_end = p + a_len[p];
            end
        end
        e_kind = '0; e_byte = '0; e_len = '0; e_dist = '0;
        q = m_carry;
        for (int k = 0; k < V; k++) begin
            if (k < q) begin
                e_kind[k*2 +: 2] = 2'd2;
            end else if (k == best) begin
                e_kind[k*2 +: 2]   = 2'd1;
                e_len[k*LW +: LW]  = LW'(a_len[k]);
                e_dist[k*DW +: DW] = DW'(a_dist[k]);
                q = k + a_len[k];
            end else begin
                int eff = a_len[k];
                if (best >= 0 && k < best && best - k < eff) eff = best - k;
                if (a_dist[k] != 0 && a_len[k] >= ML && eff >= ML) begin
                    e_kind[k*2 +: 2]   = 2'd1;
                    e_len[k*LW +: LW]  = LW'(eff);
                    e_dist[k*DW +: DW] = DW'(a_dist[k]);
                    q = k + eff;
                end else begin
                    e_byte[k*8 +: 8] = 8'(a_byte[k]);
                    q = k + 1;
                end
            end
        end
        m_carry = (best >= 0 && best_end > V) ? best_end - V : 0;
    endfunction

    task automatic send(input string tag);
        @(negedge clk);
        for (int k = 0; k < V; k++) begin
            in_byte[k*8 +: 8]  = 8'(a_byte[k]);
            in_len[k*LW +: LW] = LW'(a_len[k]);
            in_dist[k*DW +: DW] = DW'(a_dist[k]);
        end
        in_valid = 1'b1;
        compute_expect();
        q_kind.push_back(e_kind);
        q_byte.push_back(e_byte);
        q_len.push_back(e_len);
        q_dist.push_back(e_dist);
        q_tag.push_back(tag);
        q_stamp.push_back(cyc);
    endtask

    task automatic bubble();
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = {V{8'($urandom)}};
        in_len   = '1;
        in_dist  = '1;
    endtask

    task automatic clear_win();
        for (int k = 0; k < V; k++) begin
            a_byte[k] = 8'h40 + k;
            a_len[k]  = k % 3;
            a_dist[k] = 0;
        end
    endtask

    task automatic rand_win();
        for (int k = 0; k < V; k++) begin
            a_byte[k] = $urandom % 256;
            a_len[k]  = $urandom % (V + 1);
            a_dist[k] = ($urandom % 2 == 1) ? 1 + ($urandom % 63) : 0;
        end
    endtask

    // Output monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q_tag.size() == 0) begin
                checks++; failures++;
                $display("FAIL R10 unexpected window act=%h exp=none", out_kind);
            end else begin
                logic [V*2-1:0]  xk;
                logic [V*8-1:0]  xb;
                logic [V*LW-1:0] xl;
                logic [V*DW-1:0] xd;
                string t;
                int st;
                xk = q_kind.pop_front(); xb = q_byte.pop_front();
                xl = q_len.pop_front();  xd = q_dist.pop_front();
                t = q_tag.pop_front();   st = q_stamp.pop_front();
                checks++;
                if (out_kind !== xk || out_byte !== xb || out_len !== xl || out_dist !== xd) begin
                    failures++;
                    $display("FAIL %s kind act=%h exp=%h byte act=%h exp=%h len act=%h exp=%h dist act=%h exp=%h",
                             t, out_kind, xk, out_byte, xb, out_len, xl, out_dist, xd);
                end
                checks++;
                if (cyc - st != LAT) begin
                    failures++;
                    $display("FAIL R10 latency act=%0d exp=%0d", cyc - st, LAT);
                end
            end
        end
    end

    task automatic reset_check(input string tag);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        m_carry = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL %s out_valid during reset act=%b exp=0", tag, out_valid);
        end
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog expired act=hung exp=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        reset_check("R1");

        // R2: literals, including a short nonzero-distance candidate
        clear_win();
        a_dist[3] = 7; a_len[3] = 2;
        send("R1/R2 literal window");

        // R3/R5/R6: position 2 reaches two past the window end
        clear_win();
        a_dist[2] = 5; a_len[2] = 8;
        send("R3/R5 long match");
        bubble();
        bubble();

        // R6/R7: carried coverage of 2; position 0 would reach farthest but is ignored
        clear_win();
        a_dist[0] = 1; a_len[0] = 8;
        a_dist[5] = 4; a_len[5] = 3;
        send("R6/R7 carry and ignore");

        // R4: equal reach at positions 1 and 2
        clear_win();
        a_dist[1] = 9; a_len[1] = 4;
        a_dist[2] = 3; a_len[2] = 3;
        send("R4 tie");

        // R8/R9: gap match kept, following candidate truncated below minimum
        clear_win();
        a_dist[0] = 9; a_len[0] = 4;
        a_dist[4] = 2; a_len[4] = 3;
        a_dist[5] = 6; a_len[5] = 3;
        send("R8/R9 gap walk");

        // R9: gap match truncated but still long enough
        clear_win();
        a_dist[0] = 3; a_len[0] = 7;
        a_dist[4] = 11; a_len[4] = 4;
        send("R9 truncate");

        // Leave coverage pending, then reset: it must be dropped
        clear_win();
        a_dist[6] = 2; a_len[6] = 6;
        send("R6 pending carry");
        repeat (LAT + 2) bubble();
        reset_check("R1 mid-run");
        clear_win();
        send("R1 no carry after reset");

        // Random windows with random bubbles
        for (int n = 0; n < 400; n++) begin
            if ($urandom % 5 == 0) bubble();
            rand_win();
            send("R3/R8 random");
        end

        repeat (LAT + 4) bubble();
        checks++;
        if (q_tag.size() != 0) begin
            failures++;
            $display("FAIL R10 windows missing act=%0d exp=0", q_tag.size());
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule